// File: doc/BRIEF.md
# Dual Audio Baud-Rate Tick Generator

The block makes two programmable tick streams for an audio subsystem. Generator A is meant for sources that are multiples of 44.1 kHz and generator B for sources that are multiples of 48 kHz. Each generator takes one of four incoming tick-enable sources and divides it. The division is done in two stages: a power-of-four prescaler, then an 8-bit counter. A third output passes the ticks of one generator to a single audio clock-out enable. A control bit chooses which generator.

All inputs and outputs are single-cycle enables in the system clock domain. No derived clocks are made. A simple synchronous write port and a combinational read port give access to three words: a control word and one divider word for each generator. The software that programs these words picks the divider values. It never writes a value that cannot be represented.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, both divider words read 0x002 (prescaler code 0, count 2, so division by 6). The control word reads 0. All tick outputs are low.
- R2: A generator counts the source ticks it accepts. When its divider word holds prescaler code p in bits 9:8 and count N in bits 7:0, the ratio is (2 << 2p) * (N+1). The generator raises its tick output for exactly one cycle, in the cycle after the source tick that completes each ratio. The prescaler ratios are therefore 2, 8, 32 and 128.
- R3: Generator A takes its source code from control bits 22:20 and generator B from bits 18:16. Code 0 selects src_tick_i[0], code 1 selects src_tick_i[1], code 2 selects src_tick_i[2] (the internal source), and code 4 selects src_tick_i[3].
- R4: Source codes 3, 5, 6 and 7 select no input. A generator holding such a code produces no ticks.
- R5: A control write keeps only the bits under mask 0x80770000. A control read returns zero in every other bit.
- R6: clkout_tick_o follows tick_b_o when control bit 31 is set and tick_a_o when it is clear.
- R7: Writing a divider word clears that generator's prescaler and counter. A control write that changes a generator's source code does the same for that generator. A control write that leaves a source code unchanged does not clear that generator. In a cycle where a generator is cleared, its source tick is not counted and its tick output is low in the following cycle.
- R8: Address 0 is the control word, 1 is divider A, 2 is divider B. A divider write keeps only data bits 9:0, and a divider read returns them with bits 31:10 at zero. Address 3 ignores writes and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_tick_i | input | 4 | Source tick enables: [0] input A, [1] input B, [2] internal input, [3] input C |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| tick_a_o | output | 1 | Tick enable of generator A (44.1 kHz family) |
| tick_b_o | output | 1 | Tick enable of generator B (48 kHz family) |
| clkout_tick_o | output | 1 | Audio clock-out enable, from A or B |

## Verification
The assertions check these properties on every cycle:
- each tick lasts a single cycle;
- an invalid source code gives no tick;
- the cycle after a divider write has no tick;
- control and divider reads are zero outside their masks, and the unused address reads zero;
- the clock-out enable only rises when one of the generators ticks.

Some behaviour can only be shown by the bench's scenarios, which compare the outputs against a reference model on every clock:
- the exact division ratio for each prescaler code and count;
- the mapping of the non-contiguous source codes to inputs;
- choosing which generator drives the clock-out enable;
- the difference between a control write that clears a generator and one that does not.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  localparam int SRC_N   = 4;
  localparam int SEL_W   = 3;
  localparam int PCODE_W = 2;
  localparam int CNT_W   = 8;
  localparam int DIV_W   = PCODE_W + CNT_W;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;

  localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h8077_0000;
  localparam int OUT_SEL_BIT = 31;
  localparam int SEL_A_LSB   = 20;
  localparam int SEL_B_LSB   = 16;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_DIV_A = 2'd1,
    ADDR_DIV_B = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic             out_b;
    logic [SEL_W-1:0] sel_a;
    logic [SEL_W-1:0] sel_b;
  } ctrl_t;

  // Non-contiguous source code to one-hot input select; unlisted codes select nothing.
  function automatic logic [SRC_N-1:0] sel_onehot(logic [SEL_W-1:0] code);
    case (code)
      3'd0:    return 4'b0001;
      3'd1:    return 4'b0010;
      3'd2:    return 4'b0100;
      3'd4:    return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/baud_tick_regs.sv
module baud_tick_regs
  import baud_tick_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int DIVW  = DIV_W,
  parameter int SW    = SEL_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [DW-1:0]   rd_data_o,
  output ctrl_t           ctrl_o,
  output logic [DIVW-1:0] div_a_o,
  output logic [DIVW-1:0] div_b_o,
  output logic [1:0]      clr_o
);

  localparam logic [DIVW-1:0] DIV_RST = DIVW'(2);

  ctrl_t           ctrl_q, ctrl_wr;
  logic [DIVW-1:0] div_a_q, div_b_q;
  reg_addr_e       wa, ra;

  assign wa = reg_addr_e'(wr_addr_i);
  assign ra = reg_addr_e'(rd_addr_i);

  assign ctrl_wr.out_b = wr_data_i[OUT_SEL_BIT];
  assign ctrl_wr.sel_a = wr_data_i[SEL_A_LSB +: SW];
  assign ctrl_wr.sel_b = wr_data_i[SEL_B_LSB +: SW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      div_a_q <= DIV_RST;
      div_b_q <= DIV_RST;
    end else if (wr_en_i) begin
      case (wa)
        ADDR_CTRL:  ctrl_q  <= ctrl_wr;
        ADDR_DIV_A: div_a_q <= wr_data_i[DIVW-1:0];
        ADDR_DIV_B: div_b_q <= wr_data_i[DIVW-1:0];
        default:    ;
      endcase
    end
  end

  // Clear a generator on its divider write or on a change of its source code.
  always_comb begin
    clr_o = 2'b00;
    if (wr_en_i) begin
      case (wa)
        ADDR_CTRL: begin
          clr_o[0] = (ctrl_wr.sel_a != ctrl_q.sel_a);
          clr_o[1] = (ctrl_wr.sel_b != ctrl_q.sel_b);
        end
        ADDR_DIV_A: clr_o[0] = 1'b1;
        ADDR_DIV_B: clr_o[1] = 1'b1;
        default:    ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (ra)
      ADDR_CTRL: begin
        rd_data_o[OUT_SEL_BIT]        = ctrl_q.out_b;
        rd_data_o[SEL_A_LSB +: SW]    = ctrl_q.sel_a;
        rd_data_o[SEL_B_LSB +: SW]    = ctrl_q.sel_b;
      end
      ADDR_DIV_A: rd_data_o[DIVW-1:0] = div_a_q;
      ADDR_DIV_B: rd_data_o[DIVW-1:0] = div_b_q;
      default:    ;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign div_a_o = div_a_q;
  assign div_b_o = div_b_q;

endmodule

// File: rtl/baud_tick_div.sv
module baud_tick_div
  import baud_tick_pkg::*;
#(
  parameter int NSRC = SRC_N,
  parameter int SW   = SEL_W,
  parameter int PW   = PCODE_W,
  parameter int CW   = CNT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [NSRC-1:0] src_tick_i,
  input  logic [SW-1:0]   sel_i,
  input  logic [PW-1:0]   pre_code_i,
  input  logic [CW-1:0]   count_i,
  output logic            tick_o
);

  localparam int NCODE = 1 << PW;
  // Largest prescaler limit is (2 << 2*(NCODE-1)) - 1.
  localparam int PRE_W = 1 + 2 * (NCODE - 1);

  logic [PRE_W-1:0] pre_q, pre_lim;
  logic [CW-1:0]    cnt_q;
  logic             tick_q;
  logic             hit;

  assign hit = |(src_tick_i & sel_onehot(sel_i));

  always_comb begin
    pre_lim = '0;
    for (int k = 0; k < NCODE; k++) begin
      if (pre_code_i == PW'(k)) pre_lim = PRE_W'((2 << (2 * k)) - 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (clr_i) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (hit) begin
        if (pre_q == pre_lim) begin
          pre_q <= '0;
          if (cnt_q == count_i) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int NSRC = SRC_N,
  parameter int PW   = PCODE_W,
  parameter int CW   = CNT_W,
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_tick_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            tick_a_o,
  output logic            tick_b_o,
  output logic            clkout_tick_o
);

  localparam int DIVW  = PW + CW;
  localparam int NGEN  = 2;

  ctrl_t                      ctrl_q;
  logic [NGEN-1:0][DIVW-1:0]  div_w;
  logic [NGEN-1:0][SEL_W-1:0] sel_w;
  logic [NGEN-1:0]            clr;
  logic [NGEN-1:0]            tick;
  logic [SEL_W-1:0]           sel_a, sel_b;

  baud_tick_regs #(
    .DW   (DW),
    .AW   (AW),
    .DIVW (DIVW),
    .SW   (SEL_W)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .ctrl_o    (ctrl_q),
    .div_a_o   (div_w[0]),
    .div_b_o   (div_w[1]),
    .clr_o     (clr)
  );

  assign sel_a    = ctrl_q.sel_a;
  assign sel_b    = ctrl_q.sel_b;
  assign sel_w[0] = sel_a;
  assign sel_w[1] = sel_b;

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    baud_tick_div #(
      .NSRC (NSRC),
      .SW   (SEL_W),
      .PW   (PW),
      .CW   (CW)
    ) i_div (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr[g]),
      .src_tick_i (src_tick_i),
      .sel_i      (sel_w[g]),
      .pre_code_i (div_w[g][DIVW-1 -: PW]),
      .count_i    (div_w[g][CW-1:0]),
      .tick_o     (tick[g])
    );
  end

  assign tick_a_o      = tick[0];
  assign tick_b_o      = tick[1];
  assign clkout_tick_o = ctrl_q.out_b ? tick[1] : tick[0];

endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  wr_addr_i,
  input logic [1:0]  rd_addr_i,
  input logic [31:0] rd_data_o,
  input logic        tick_a_o,
  input logic        tick_b_o,
  input logic        clkout_tick_o,
  input logic [2:0]  sel_a_i,
  input logic [2:0]  sel_b_i
);

  logic bad_a, bad_b;
  assign bad_a = (sel_a_i == 3'd3) || (sel_a_i > 3'd4);
  assign bad_b = (sel_b_i == 3'd3) || (sel_b_i > 3'd4);

  AST_TICK_A_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_a_o |=> !tick_a_o); // R2
  AST_TICK_B_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_b_o |=> !tick_b_o); // R2
  AST_NOSRC_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bad_a) |-> !tick_a_o); // R4
  AST_NOSRC_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bad_b) |-> !tick_b_o); // R4
  AST_CTRL_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == 2'd0) |-> ((rd_data_o & ~32'h8077_0000) == 32'h0)); // R5
  AST_CLKOUT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clkout_tick_o |-> (tick_a_o || tick_b_o)); // R6
  AST_DIV_CLR_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && wr_addr_i == 2'd1) |-> !tick_a_o); // R7
  AST_DIV_CLR_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && wr_addr_i == 2'd2) |-> !tick_b_o); // R7
  AST_DIV_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == 2'd1 || rd_addr_i == 2'd2) |-> (rd_data_o[31:10] == 22'h0)); // R8
  AST_NONE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == 2'd3) |-> (rd_data_o == 32'h0)); // R8

endmodule

bind baud_tick_gen baud_tick_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .rd_addr_i     (rd_addr_i),
  .rd_data_o     (rd_data_o),
  .tick_a_o      (tick_a_o),
  .tick_b_o      (tick_b_o),
  .clkout_tick_o (clkout_tick_o),
  .sel_a_i       (sel_a),
  .sel_b_i       (sel_b)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  src_tick_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        tick_a_o, tick_b_o, clkout_tick_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  logic [9:0] m_div [2];
  logic [2:0] m_sel [2];
  logic       m_outb;
  int         acc [2];
  bit         exp_tick [2];

  baud_tick_gen i_baud_tick_gen (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .src_tick_i    (src_tick_i),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .rd_addr_i     (rd_addr_i),
    .rd_data_o     (rd_data_o),
    .tick_a_o      (tick_a_o),
    .tick_b_o      (tick_b_o),
    .clkout_tick_o (clkout_tick_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  function automatic int ratio(logic [9:0] d);
    return (2 << (2 * int'(d[9:8]))) * (int'(d[7:0]) + 1);
  endfunction

  function automatic int src_idx(logic [2:0] c);
    case (c)
      3'd0: return 0;
      3'd1: return 1;
      3'd2: return 2;
      3'd4: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] model_read(logic [1:0] a);
    case (a)
      2'd0: return {m_outb, 8'h00, m_sel[0], 1'b0, m_sel[1], 16'h0000};
      2'd1: return {22'h0, m_div[0]};
      2'd2: return {22'h0, m_div[1]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=0x%0h expected=0x%0h", tag, cycles, act, exp);
    end
  endtask

  task automatic model_reset();
    m_div[0] = 10'h002; m_div[1] = 10'h002;
    m_sel[0] = 3'd0;    m_sel[1] = 3'd0;
    m_outb = 1'b0;
    acc[0] = 0; acc[1] = 0;
    exp_tick[0] = 0; exp_tick[1] = 0;
  endtask

  // One clock: update the model from the inputs, cross the edge, compare.
  task automatic cyc();
    bit clr [2];
    clr[0] = 0; clr[1] = 0;
    if (wr_en_i) begin
      case (wr_addr_i)
        2'd0: begin
          clr[0] = (wr_data_i[22:20] != m_sel[0]);
          clr[1] = (wr_data_i[18:16] != m_sel[1]);
        end
        2'd1: clr[0] = 1;
        2'd2: clr[1] = 1;
        default: ;
      endcase
    end
    for (int g = 0; g < 2; g++) begin
      exp_tick[g] = 0;
      if (clr[g]) begin
        acc[g] = 0;
      end else if (src_idx(m_sel[g]) >= 0 && src_tick_i[src_idx(m_sel[g])]) begin
        acc[g]++;
        if (acc[g] >= ratio(m_div[g])) begin
          acc[g] = 0;
          exp_tick[g] = 1;
        end
      end
    end
    if (wr_en_i) begin
      case (wr_addr_i)
        2'd0: begin
          m_outb   = wr_data_i[31];
          m_sel[0] = wr_data_i[22:20];
          m_sel[1] = wr_data_i[18:16];
        end
        2'd1: m_div[0] = wr_data_i[9:0];
        2'd2: m_div[1] = wr_data_i[9:0];
        default: ;
      endcase
    end
    @(posedge clk_i);
    @(negedge clk_i);
    cycles++;
    check("R2 tick_a", 32'(tick_a_o), 32'(exp_tick[0]));
    check("R2 tick_b", 32'(tick_b_o), 32'(exp_tick[1]));
    check("R6 clkout", 32'(clkout_tick_o), 32'(m_outb ? exp_tick[1] : exp_tick[0]));
    check("R8 read", rd_data_o, model_read(rd_addr_i));
    wr_en_i = 1'b0;
  endtask

  task automatic run(int n, logic [3:0] mask, bit rnd);
    for (int i = 0; i < n; i++) begin
      src_tick_i = rnd ? (4'($urandom) & mask) : mask;
      rd_addr_i  = 2'(i);
      cyc();
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, logic [3:0] src);
    wr_en_i    = 1'b1;
    wr_addr_i  = a;
    wr_data_i  = d;
    src_tick_i = src;
    cyc();
  endtask

  task automatic rd_check(string tag, logic [1:0] a, logic [31:0] exp);
    rd_addr_i = a;
    #1;
    check(tag, rd_data_o, exp);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1 tick_a", 32'(tick_a_o), 32'h0);
    check("R1 tick_b", 32'(tick_b_o), 32'h0);
    check("R1 clkout", 32'(clkout_tick_o), 32'h0);
    rst_ni = 1'b1;
    rd_check("R1 div_a", 2'd1, 32'h002);
    rd_check("R1 div_b", 2'd2, 32'h002);
    rd_check("R1 ctrl", 2'd0, 32'h0);

    // R2: default ratio 6 on input A, both generators
    run(40, 4'b0001, 0);
    run(60, 4'b1111, 1);
    // R2: p=1 N=2 -> 24, p=0 N=0 -> 2
    wr(2'd1, 32'h0000_0102, 4'b0001);
    wr(2'd2, 32'h0000_0000, 4'b0001);
    run(200, 4'b1111, 1);
    // R3 R5 R6: A from input C, B from internal input, clock-out from B, junk bits dropped
    wr(2'd0, 32'h8042_1234, 4'b1111);
    rd_check("R5 ctrl", 2'd0, 32'h8042_0000);
    run(200, 4'b1111, 1);
    wr(2'd0, 32'h0011_0000, 4'b0011);
    run(150, 4'b1111, 1);
    // R4 R5: all ones -> codes 7/7, nothing counts
    wr(2'd0, 32'hFFFF_FFFF, 4'b1111);
    rd_check("R5 ctrl ones", 2'd0, 32'h8077_0000);
    run(100, 4'b1111, 0);
    wr(2'd0, 32'h0035_0000, 4'b1111);
    run(100, 4'b1111, 0);
    wr(2'd0, 32'h0066_0000, 4'b1111);
    run(100, 4'b1111, 0);
    // R2: full 8-bit count and largest prescaler
    wr(2'd0, 32'h0000_0000, 4'b0001);
    wr(2'd1, 32'h0000_00FF, 4'b0001);
    wr(2'd2, 32'h0000_0340, 4'b0001);
    run(300, 4'b0001, 0);
    // R7: rewrite same divider mid-count restarts A only
    wr(2'd1, 32'h0000_00FF, 4'b0001);
    run(700, 4'b0001, 0);
    // R7: control write with same codes does not clear
    wr(2'd0, 32'h8000_0000, 4'b0001);
    run(9000, 4'b0001, 0);
    // R7: code change clears A only
    wr(2'd0, 32'h8010_0000, 4'b0011);
    run(1200, 4'b0011, 1);
    // R8: unused address ignores writes, divider write keeps low 10 bits
    wr(2'd3, 32'hFFFF_FFFF, 4'b0001);
    rd_check("R8 none", 2'd3, 32'h0);
    wr(2'd2, 32'hFFFF_FC01, 4'b0001);
    rd_check("R8 div_b", 2'd2, 32'h0000_0001);
    run(100, 4'b1111, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n = 0;
    while (!done) begin
      @(posedge clk_i);
      n++;
      if (n >= WATCHDOG && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired after %0d cycles", n);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

endmodule